// File: doc/BRIEF.md
# Micro-Address Sequencer with Opcode Dispatch and Exception Branch

This block holds the micro-program counter of a microcoded controller and
chooses, once per clock, the micro-address that the control store reads next.
The current micro-instruction supplies a 2-bit sequencing field. That field
selects one of four sources for the next address:

- return to the fetch routine at address zero;
- a jump through a fixed opcode lookup table;
- a step to the next address;
- a conditional micro-branch. The branch is taken when an arithmetic overflow or a pending interrupt is flagged, and this is how the controller enters its exception micro-routines.

The control store itself sits outside the block. The micro-address output comes straight from the micro-PC register, so the control store can read it in the same cycle without an extra stage. An opcode that the lookup table does not hold sends the controller to a fixed reserved-instruction micro-routine. The table therefore never leaves the controller at an undefined address.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `uaddr` becomes 0 at that edge, whatever the other inputs are.
- R2: With `seq_sel` = 2'b00, the next `uaddr` is 0, the fetch routine.
- R3: With `seq_sel` = 2'b01, the next `uaddr` comes from the opcode table: 6'b000000 gives 4, 6'b000100 gives 3, 6'b001101 gives 6, 6'b100011 gives 8 and 6'b101011 gives 11.
- R4: With `seq_sel` = 2'b01 and an opcode that is not in the table, the next `uaddr` is `RI_UADDR` (default 16).
- R5: With `seq_sel` = 2'b10, the next `uaddr` is the current `uaddr` plus one, and it wraps from all ones to 0.
- R6: With `seq_sel` = 2'b11 and either `ovf` or `irq_pend` high, the next `uaddr` is `br_target`.
- R7: With `seq_sel` = 2'b11 and both `ovf` and `irq_pend` low, the next `uaddr` is the current `uaddr` plus one.
- R8: `opcode` has no effect unless `seq_sel` = 2'b01. `ovf`, `irq_pend` and `br_target` have no effect unless `seq_sel` = 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_sel | input | 2 | Sequencing field of the current micro-instruction |
| opcode | input | OP_W | Opcode of the instruction being decoded |
| ovf | input | 1 | Arithmetic overflow flag |
| irq_pend | input | 1 | Pending interrupt flag |
| br_target | input | UADDR_W | Micro-branch target address |
| uaddr | output | UADDR_W | Registered micro-address fed to the control store |

## Verification
The bench builds the sequencer with the default parameters: a 6-bit opcode, a 5-bit micro-address and the reserved-instruction routine at address 16. With these values all five table entries and an address above every table target can be reached. The taken branch also reaches the top address 31, so the wrap of the incrementer can be seen in two steps. Before each check that an input has no effect, the micro-PC is first set to a known value through a taken branch.

// File: rtl/useq_pkg.sv
package useq_pkg;

  // Sequencing field encodings
  typedef enum logic [1:0] {
    SEQ_FETCH  = 2'b00,
    SEQ_DISP   = 2'b01,
    SEQ_NEXT   = 2'b10,
    SEQ_BRANCH = 2'b11
  } seq_e;

  localparam int TAB_OP_W    = 6;
  localparam int TAB_TGT_W   = 4;
  localparam int TAB_ENTRIES = 5;

  // Dispatch table: opcode to first micro-address of its routine
  localparam logic [TAB_OP_W-1:0] TAB_OPC [TAB_ENTRIES] = '{
    6'b000000,  // register-register ALU
    6'b000100,  // branch on equal
    6'b001101,  // or immediate
    6'b100011,  // load word
    6'b101011   // store word
  };

  localparam logic [TAB_TGT_W-1:0] TAB_TGT [TAB_ENTRIES] = '{
    4'd4, 4'd3, 4'd6, 4'd8, 4'd11
  };

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int OP_W     = 6,
  parameter int UADDR_W  = 5,
  parameter int RI_UADDR = 16
) (
  input  logic [OP_W-1:0]    opcode,
  output logic [UADDR_W-1:0] disp_addr
);

  logic [TAB_ENTRIES-1:0] hit;
  logic [UADDR_W-1:0]     masked [TAB_ENTRIES];

  for (genvar g = 0; g < TAB_ENTRIES; g++) begin : g_entry
    assign hit[g]    = (opcode == OP_W'(TAB_OPC[g]));
    assign masked[g] = hit[g] ? UADDR_W'(TAB_TGT[g]) : '0;
  end

  always_comb begin
    disp_addr = '0;
    for (int i = 0; i < TAB_ENTRIES; i++) begin
      disp_addr = disp_addr | masked[i];
    end
    if (hit == '0) begin
      disp_addr = UADDR_W'(RI_UADDR);
    end
  end

endmodule

// File: rtl/useq_next.sv
module useq_next
  import useq_pkg::*;
#(
  parameter int UADDR_W = 5
) (
  input  logic [1:0]         seq_sel,
  input  logic [UADDR_W-1:0] cur_addr,
  input  logic [UADDR_W-1:0] disp_addr,
  input  logic               cond,
  input  logic [UADDR_W-1:0] br_target,
  output logic [UADDR_W-1:0] nxt_addr
);

  logic [UADDR_W-1:0] inc_addr;

  // Dedicated incrementer, wraps naturally at the address width
  assign inc_addr = cur_addr + UADDR_W'(1);

  always_comb begin
    unique case (seq_sel)
      SEQ_FETCH:  nxt_addr = '0;
      SEQ_DISP:   nxt_addr = disp_addr;
      SEQ_NEXT:   nxt_addr = inc_addr;
      SEQ_BRANCH: nxt_addr = cond ? br_target : inc_addr;
      default:    nxt_addr = '0;
    endcase
  end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
  parameter int OP_W     = 6,
  parameter int UADDR_W  = 5,
  parameter int RI_UADDR = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         seq_sel,
  input  logic [OP_W-1:0]    opcode,
  input  logic               ovf,
  input  logic               irq_pend,
  input  logic [UADDR_W-1:0] br_target,
  output logic [UADDR_W-1:0] uaddr
);

  logic [UADDR_W-1:0] disp_addr;
  logic [UADDR_W-1:0] nxt_addr;
  logic               cond;

  assign cond = ovf | irq_pend;

  useq_dispatch #(
    .OP_W    (OP_W),
    .UADDR_W (UADDR_W),
    .RI_UADDR(RI_UADDR)
  ) u_dispatch (
    .opcode   (opcode),
    .disp_addr(disp_addr)
  );

  useq_next #(
    .UADDR_W(UADDR_W)
  ) u_next (
    .seq_sel  (seq_sel),
    .cur_addr (uaddr),
    .disp_addr(disp_addr),
    .cond     (cond),
    .br_target(br_target),
    .nxt_addr (nxt_addr)
  );

  // Micro-PC register
  always_ff @(posedge clk) begin
    if (rst) begin
      uaddr <= '0;
    end else begin
      uaddr <= nxt_addr;
    end
  end

endmodule

// File: rtl/useq_sequencer_chk.sv
module useq_sequencer_chk #(
  parameter int OP_W     = 6,
  parameter int UADDR_W  = 5,
  parameter int RI_UADDR = 16
) (
  input logic               clk,
  input logic               rst,
  input logic [1:0]         seq_sel,
  input logic [OP_W-1:0]    opcode,
  input logic               ovf,
  input logic               irq_pend,
  input logic [UADDR_W-1:0] br_target,
  input logic [UADDR_W-1:0] uaddr
);

  logic known_op;
  assign known_op = (opcode == OP_W'(6'b000000)) || (opcode == OP_W'(6'b000100)) ||
                    (opcode == OP_W'(6'b001101)) || (opcode == OP_W'(6'b100011)) ||
                    (opcode == OP_W'(6'b101011));

  p_reset_zero_r1: assert property (@(posedge clk)
    rst |=> (uaddr == '0));

  p_fetch_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b00) |=> (uaddr == '0));

  p_dispatch_lw_r3: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b01 && opcode == OP_W'(6'b100011)) |=> (uaddr == UADDR_W'(8)));

  p_dispatch_ri_r4: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b01 && !known_op) |=> (uaddr == UADDR_W'(RI_UADDR)));

  p_step_r5: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b10) |=> (uaddr == UADDR_W'($past(uaddr) + 1'b1)));

  p_taken_r6: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b11 && (ovf || irq_pend)) |=> (uaddr == $past(br_target)));

  p_fall_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_sel == 2'b11 && !ovf && !irq_pend) |=> (uaddr == UADDR_W'($past(uaddr) + 1'b1)));

endmodule

bind useq_sequencer useq_sequencer_chk #(
  .OP_W    (OP_W),
  .UADDR_W (UADDR_W),
  .RI_UADDR(RI_UADDR)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .seq_sel  (seq_sel),
  .opcode   (opcode),
  .ovf      (ovf),
  .irq_pend (irq_pend),
  .br_target(br_target),
  .uaddr    (uaddr)
);

// File: tb/test_useq_sequencer.sv
`timescale 1ns/1ps
module test_useq_sequencer;

  localparam int OP_W = 6;
  localparam int AW   = 5;
  localparam int RI   = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    seq_sel = 2'b00;
  logic [OP_W-1:0] opcode = '0;
  logic          ovf = 1'b0;
  logic          irq_pend = 1'b0;
  logic [AW-1:0] br_target = '0;
  logic [AW-1:0] uaddr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  useq_sequencer #(.OP_W(OP_W), .UADDR_W(AW), .RI_UADDR(RI)) i_useq_sequencer (
    .clk(clk), .rst(rst), .seq_sel(seq_sel), .opcode(opcode),
    .ovf(ovf), .irq_pend(irq_pend), .br_target(br_target), .uaddr(uaddr)
  );

  task automatic chk(input string req, input logic [AW-1:0] exp);
    checks++;
    if (uaddr !== exp) begin
      errors++;
      $display("FAIL %s uaddr=%0d expected=%0d", req, uaddr, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the next rising edge
  task automatic step(input logic [1:0] s, input logic [OP_W-1:0] op,
                      input logic o, input logic ip, input logic [AW-1:0] t);
    @(negedge clk);
    seq_sel = s; opcode = op; ovf = o; irq_pend = ip; br_target = t;
    @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [AW-1:0] a);
    step(2'b11, '0, 1'b1, 1'b0, a);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(2'b10, '0, 1'b0, 1'b0, '0);
    chk("R1 reset", '0);
    step(2'b11, 6'b100011, 1'b1, 1'b1, 5'd9);
    chk("R1 reset over branch", '0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_fetch;
    load(5'd13);
    step(2'b00, 6'b000100, 1'b1, 1'b1, 5'd7);
    chk("R2 fetch", '0);
  endtask

  task automatic t_dispatch;
    logic [OP_W-1:0] ops [5] = '{6'b000000, 6'b000100, 6'b001101, 6'b100011, 6'b101011};
    logic [AW-1:0]   exp [5] = '{5'd4, 5'd3, 5'd6, 5'd8, 5'd11};
    for (int i = 0; i < 5; i++) begin
      load(5'd30);
      step(2'b01, ops[i], 1'b0, 1'b0, '0);
      chk("R3 dispatch", exp[i]);
    end
  endtask

  task automatic t_dispatch_unknown;
    step(2'b01, 6'b111111, 1'b0, 1'b0, '0);
    chk("R4 unknown 111111", 5'd16);
    step(2'b01, 6'b000010, 1'b0, 1'b0, '0);
    chk("R4 unknown 000010", 5'd16);
  endtask

  task automatic t_step_wrap;
    load(5'd5);
    step(2'b10, '0, 1'b0, 1'b0, '0);
    chk("R5 step", 5'd6);
    load(5'd31);
    chk("R6 branch to top", 5'd31);
    step(2'b10, '0, 1'b0, 1'b0, '0);
    chk("R5 wrap", 5'd0);
  endtask

  task automatic t_branch;
    load(5'd2);
    step(2'b11, '0, 1'b0, 1'b1, 5'd20);
    chk("R6 irq taken", 5'd20);
    step(2'b11, '0, 1'b1, 1'b0, 5'd25);
    chk("R6 ovf taken", 5'd25);
    step(2'b11, '0, 1'b1, 1'b1, 5'd17);
    chk("R6 both taken", 5'd17);
  endtask

  task automatic t_fall;
    load(5'd9);
    step(2'b11, 6'b100011, 1'b0, 1'b0, 5'd28);
    chk("R7 fall through", 5'd10);
  endtask

  task automatic t_ignored;
    load(5'd7);
    step(2'b10, 6'b100011, 1'b1, 1'b1, 5'd3);
    chk("R8 step ignores opcode/flags/target", 5'd8);
    step(2'b01, 6'b001101, 1'b1, 1'b1, 5'd27);
    chk("R8 dispatch ignores flags/target", 5'd6);
    load(5'd12);
    step(2'b00, 6'b101011, 1'b1, 1'b0, 5'd19);
    chk("R8 fetch ignores inputs", 5'd0);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_fetch();
    t_dispatch();
    t_dispatch_unknown();
    t_step_wrap();
    t_branch();
    t_fall();
    t_ignored();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule